// File: doc/BRIEF.md
# Flash Erase and Program Control Registers

This block sits on a processor's special-function register bus and gates every change to an on-chip flash. Software arms an erase by writing a page number or setting an enable bit, then writes a fixed code value to a trigger location. The block checks that the matching arming write happened and that any other condition holds. Only then does it issue a one-cycle erase request to the flash back end. It shows busy until the back end reports completion.

The same control register holds a program-write enable. While that bit is set, the next external-memory write from the core goes to flash rather than external RAM, and the bit then drops by itself. It also holds a sticky security bit that drives a read-protect output. Each arming is good for one attempt only, so software must repeat it before every erase.

Top module: `flash_erase_ctl`

## Requirements
- R1: After reset all three registers read 0x00, and `prog_sel`, `read_protect`, `busy` and `erase_req` are low. The trigger at address 0x94 always reads 0x00.
- R2: Writing 0x55 to 0x94 while not busy issues a page erase, but only if 0xB7 was written since the last page-erase attempt. `erase_req` is high for the one cycle after the write, with `erase_mass`=0 and `erase_page` equal to bits 7:1 of 0xB7.
- R3: Writing 0xAA to 0x94 while not busy issues a mass erase (`erase_mass`=1), but only if control bit 1 (address 0xB2) is 1 and `dbg_en` is high.
- R4: Any other value written to 0x94 has no effect and leaves both armings intact.
- R5: A page attempt clears the page arming, and a mass attempt clears control bit 1, whether or not the attempt succeeds. A failed attempt leaves the other type's arming intact. An issued erase clears both.
- R6: `busy` rises together with `erase_req` and falls on the edge after `erase_done` is seen high. Trigger writes made while busy are ignored and consume no arming.
- R7: Control bit 0 drives `prog_sel`. It is written from bit 0 of a write to 0xB2, but only while `irq_en` is low.
- R8: An `xmem_wr` while `prog_sel` is high clears `prog_sel` on that edge.
- R9: Control bit 6 is set by writing 1 to it, writes of 0 to it are ignored, and only reset clears it. `read_protect` follows it.
- R10: Register 0xB7 reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low chip reset |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for `sfr_addr` |
| irq_en | input | 1 | Global interrupt enable state |
| dbg_en | input | 1 | Debug port enabled |
| xmem_wr | input | 1 | External-memory write from the core |
| erase_done | input | 1 | Back end finished the erase |
| erase_req | output | 1 | One-cycle erase request |
| erase_mass | output | 1 | Erase type: 1 mass, 0 page |
| erase_page | output | 7 | Page to erase |
| busy | output | 1 | Erase in progress |
| prog_sel | output | 1 | Route external-memory writes to flash |
| read_protect | output | 1 | Security flag |

## Verification
The assertions assume that `erase_done` comes only while `busy` is high and never in the same cycle as `erase_req`. They also assume that `xmem_wr` and a control-register write never arrive in the same cycle. The bench raises `erase_done` for a single cycle, and only after it has checked the request and busy state. It drives every bus write, core store and level change on the falling edge, one at a time.

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl #(
  parameter logic [7:0] TRIG_ADDR = 8'h94,
  parameter logic [7:0] PAGE_ADDR = 8'hB7,
  parameter logic [7:0] CTRL_ADDR = 8'hB2,
  parameter logic [7:0] CODE_PAGE = 8'h55,
  parameter logic [7:0] CODE_MASS = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  input  logic       irq_en,
  input  logic       dbg_en,
  input  logic       xmem_wr,
  input  logic       erase_done,
  output logic       erase_req,
  output logic       erase_mass,
  output logic [6:0] erase_page,
  output logic       busy,
  output logic       prog_sel,
  output logic       read_protect
);

  logic [7:0] page_reg;
  logic       page_armed, mass_en, pwe, secure;

  wire wr_trig = sfr_wr && sfr_addr == TRIG_ADDR && !busy;
  wire wr_page = sfr_wr && sfr_addr == PAGE_ADDR;
  wire wr_ctrl = sfr_wr && sfr_addr == CTRL_ADDR;
  wire try_page = wr_trig && sfr_wdata == CODE_PAGE;
  wire try_mass = wr_trig && sfr_wdata == CODE_MASS;
  wire go_page = try_page && page_armed;
  wire go_mass = try_mass && mass_en && dbg_en;
  wire go = go_page || go_mass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_reg   <= '0;
      page_armed <= 1'b0;
      mass_en    <= 1'b0;
      pwe        <= 1'b0;
      secure     <= 1'b0;
      erase_req  <= 1'b0;
      erase_mass <= 1'b0;
      erase_page <= '0;
      busy       <= 1'b0;
    end else begin
      erase_req <= go;
      if (wr_page) begin
        page_reg   <= sfr_wdata;
        page_armed <= 1'b1;
      end
      if (wr_ctrl) begin
        mass_en <= sfr_wdata[1];
        secure  <= secure | sfr_wdata[6];
        if (!irq_en) pwe <= sfr_wdata[0];
      end
      if (xmem_wr && pwe) pwe <= 1'b0;
      if (try_page || go) page_armed <= 1'b0;
      if (try_mass || go) mass_en <= 1'b0;
      if (go) begin
        erase_mass <= go_mass;
        erase_page <= page_reg[7:1];
        busy       <= 1'b1;
      end else if (erase_done) begin
        busy <= 1'b0;
      end
    end
  end

  assign prog_sel     = pwe;
  assign read_protect = secure;

  always_comb begin
    sfr_rdata = 8'h00;
    if (sfr_addr == PAGE_ADDR) sfr_rdata = page_reg;
    else if (sfr_addr == CTRL_ADDR) sfr_rdata = {1'b0, secure, 4'b0000, mass_en, pwe};
  end

  p_req_from_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_req) |-> !$past(busy));
  p_busy_with_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> busy);
  p_done_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && erase_done && !erase_req) |=> !busy);
  p_mass_needs_dbg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_req) && erase_mass |-> $past(dbg_en));
  p_req_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);
  p_irq_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && !xmem_wr) |=> $stable(prog_sel));
  p_self_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xmem_wr && prog_sel) |=> !prog_sel);
  p_secure_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    read_protect |=> read_protect);

endmodule

// File: tb/flash_erase_ctl_test.sv
module flash_erase_ctl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sfr_wr = 0, irq_en = 0, dbg_en = 0, xmem_wr = 0, erase_done = 0;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0;
  logic [7:0] sfr_rdata;
  logic erase_req, erase_mass, busy, prog_sel, read_protect;
  logic [6:0] erase_page;
  int runs = 0, fails = 0;

  always #2.5 clk = ~clk;

  flash_erase_ctl uut (.*);

  task automatic chk(string req, int act, int exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); sfr_wr = 1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk); sfr_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    sfr_addr = a; #0.5; d = sfr_rdata;
  endtask

  task automatic finish_erase();
    @(negedge clk); erase_done = 1;
    @(negedge clk); erase_done = 0;
    chk("R6 busy falls", busy, 0);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(8'hB7, d); chk("R1 page reg", d, 0);
    rd(8'hB2, d); chk("R1 ctrl reg", d, 0);
    rd(8'h94, d); chk("R1 trigger", d, 0);
    chk("R1 outputs", {prog_sel, read_protect, busy, erase_req}, 0);
  endtask

  task automatic t_page();
    logic [7:0] d;
    wr(8'h94, 8'h55); chk("R2 unarmed page", erase_req, 0);
    wr(8'hB7, 8'h0A);
    rd(8'hB7, d); chk("R10 readback", d, 8'h0A);
    wr(8'h94, 8'h55);
    chk("R2 req", erase_req, 1); chk("R2 type", erase_mass, 0);
    chk("R2 page", erase_page, 5); chk("R6 busy", busy, 1);
    wr(8'hB7, 8'h0C);
    wr(8'h94, 8'h55); chk("R6 ignored when busy", erase_req, 0);
    finish_erase();
    wr(8'h94, 8'h55); chk("R6 arming kept", erase_req, 1);
    chk("R2 new page", erase_page, 6);
    finish_erase();
    wr(8'h94, 8'h55); chk("R5 page arming used", erase_req, 0);
  endtask

  task automatic t_mass_fail();
    logic [7:0] d;
    dbg_en = 0;
    wr(8'hB7, 8'h10); wr(8'hB2, 8'h02);
    wr(8'h94, 8'hAA); chk("R3 no debug", erase_req, 0);
    rd(8'hB2, d); chk("R5 mass enable used", d[1], 0);
    wr(8'h94, 8'h55); chk("R5 page kept", erase_req, 1);
    chk("R5 page value", erase_page, 8);
    finish_erase();
  endtask

  task automatic t_mass_ok();
    logic [7:0] d;
    dbg_en = 1;
    wr(8'hB7, 8'h04); wr(8'hB2, 8'h02);
    wr(8'h94, 8'hAA);
    chk("R3 req", erase_req, 1); chk("R3 type", erase_mass, 1);
    rd(8'hB2, d); chk("R5 enable cleared", d[1], 0);
    finish_erase();
    wr(8'h94, 8'h55); chk("R5 both cleared", erase_req, 0);
    wr(8'h94, 8'hAA); chk("R3 unarmed mass", erase_req, 0);
  endtask

  task automatic t_other();
    logic [7:0] d;
    wr(8'hB7, 8'h02); wr(8'hB2, 8'h02);
    wr(8'h94, 8'h12); chk("R4 no req", erase_req, 0);
    rd(8'hB2, d); chk("R4 mass arming kept", d[1], 1);
    wr(8'h94, 8'h55); chk("R4 page arming kept", erase_req, 1);
    chk("R4 page", erase_page, 1);
    finish_erase();
  endtask

  task automatic t_pwe();
    irq_en = 1; wr(8'hB2, 8'h01); chk("R7 locked by irq", prog_sel, 0);
    irq_en = 0; wr(8'hB2, 8'h01); chk("R7 set", prog_sel, 1);
    @(negedge clk); xmem_wr = 1;
    @(negedge clk); xmem_wr = 0;
    chk("R8 self clear", prog_sel, 0);
  endtask

  task automatic t_secure();
    logic [7:0] d;
    wr(8'hB2, 8'h40); chk("R9 set", read_protect, 1);
    wr(8'hB2, 8'h00); chk("R9 sticky", read_protect, 1);
    rd(8'hB2, d); chk("R9 readback", d[6], 1);
  endtask

  initial begin
    fork
      begin
        #1; t_reset();
        repeat (2) @(negedge clk); rst_n = 1;
        t_page(); t_mass_fail(); t_mass_ok(); t_other(); t_pwe(); t_secure();
      end
      begin
        repeat (5000) @(posedge clk);
        chk("watchdog", 1, 0);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule